// File: doc/BRIEF.md
# Byte Register Bank with Absent Ranges and Side-Effect Registers

This block is a 256-address, byte-wide register bank that sits behind a simple host access port. A serial or parallel front end turns its transactions into single-byte beats. Most addresses below 0x80 hold plain storage bytes. A handful of addresses are handled by logic instead of storage: they mask the written value, permute its bits, or raise one-cycle pulses. Three address ranges do not exist at all.

A transaction starts with a beat that carries `acc_first` and an address. Every later beat that does not carry `acc_first` uses the address that follows the previous beat's address, wrapping from 0xFF to 0x00. A burst therefore walks the bank in order and passes straight through absent ranges. Idle cycles between beats keep the pointer where it is. Read data appears one cycle after the read beat.

Top module: `regbank_top`

## Requirements
- R1: After a synchronous active-high reset, every storage byte reads 0x00, `pwr_field`, `remap_q` and `lcd_q` are 0x00, and `rd_valid`, `reboot_pulse` and `wdog_pulse` are low.
- R2: A read beat at a storage address sets `rd_valid` in the next cycle, and `rd_data` then holds the last byte written to that address. Storage addresses are 0x00–0x57, 0x60–0x61 and 0x7F, excluding 0x20–0x23 and 0x2F.
- R3: A beat with `acc_first` high uses `acc_addr`. A beat with `acc_first` low uses the previous beat's address plus one, modulo 256.
- R4: Addresses 0x58–0x5F, 0x62–0x7E and 0x80–0xFF are absent. Reads there return 0xFF, and writes there change no storage byte and no output.
- R5: A write to 0x20 loads `pwr_field` with bits 3:0 of the written byte, visible from the next cycle. `pwr_field` changes on no other event.
- R6: A write to 0x20 with bit 2 set drives `reboot_pulse` high for exactly the next cycle. A write to 0x20 with bit 4 set does the same on `wdog_pulse`. The two pulses can be high in the same cycle.
- R7: A write to 0x21 loads `remap_q` as follows: output bit 0 takes input bit 1, bit 1 takes input bit 2, bit 3 takes input bit 0, bit 4 takes input bit 4, bit 5 takes input bit 3, and bit 6 takes input bit 5. Output bits 2 and 7 are zero, and input bits 6 and 7 are dropped.
- R8: A write to 0x22 loads `lcd_q` with the written byte ANDed with 0x3F, so bit 5 (the top backlight) passes and bits 7:6 are always zero.
- R9: Writes to 0x23 and 0x2F are accepted and have no effect on any output or storage byte.
- R10: Reads of the write-only addresses 0x20, 0x21, 0x22, 0x23 and 0x2F return 0x00.
- R11: A burst that runs into an absent range keeps incrementing. Each absent beat reads 0xFF and drops its write, and storage beyond the range is accessed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One access beat in this cycle |
| acc_first | input | 1 | Beat starts a transaction at acc_addr |
| acc_we | input | 1 | 1 = write beat, 0 = read beat |
| acc_addr | input | 8 | Start address, used when acc_first is high |
| acc_wdata | input | 8 | Write data |
| rd_valid | output | 1 | rd_data holds the result of the previous cycle's read beat |
| rd_data | output | 8 | Read data |
| pwr_field | output | 4 | Power control field from address 0x20 |
| reboot_pulse | output | 1 | One-cycle reboot request |
| wdog_pulse | output | 1 | One-cycle watchdog control strobe |
| remap_q | output | 8 | Permuted input-select register from address 0x21 |
| lcd_q | output | 8 | Display control bits from address 0x22 |

## Verification
Two functions can fall in the same cycle on a power-control write. One write to 0x20 can raise the reboot pulse, raise the watchdog strobe, and load a field value whose masked-off bit 4 is the watchdog strobe's own bit. The bench provokes this by writing 0xF4. In the following cycle it expects both pulses high together and `pwr_field` equal to 4. One cycle later it expects both pulses low and the field held. A second case is a burst whose beats alternate between storage and an absent range. There, the pointer advance and the drop of the absent write happen on the same beat, and the bench judges both by reading the whole span back.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [2:0] {
    K_POOL  = 3'd0,
    K_HOLE  = 3'd1,
    K_PWR   = 3'd2,
    K_REMAP = 3'd3,
    K_LCD   = 3'd4,
    K_STUB  = 3'd5
  } kind_e;

  localparam logic [7:0] A_PWR   = 8'h20;
  localparam logic [7:0] A_REMAP = 8'h21;
  localparam logic [7:0] A_LCD   = 8'h22;
  localparam logic [7:0] A_STUB0 = 8'h23;
  localparam logic [7:0] A_STUB1 = 8'h2F;
  localparam logic [7:0] PWR_MASK = 8'h0F;
  localparam logic [7:0] LCD_MASK = 8'h3F;
  localparam int unsigned PWR_REBOOT_BIT = 2;
  localparam int unsigned PWR_WDOG_BIT   = 4;

  function automatic logic addr_absent(input logic [7:0] a);
    return (a >= 8'h58 && a <= 8'h5F) || (a >= 8'h62 && a <= 8'h7E) || a[7];
  endfunction

  function automatic kind_e classify(input logic [7:0] a);
    if (addr_absent(a))                    return K_HOLE;
    else if (a == A_PWR)                   return K_PWR;
    else if (a == A_REMAP)                 return K_REMAP;
    else if (a == A_LCD)                   return K_LCD;
    else if (a == A_STUB0 || a == A_STUB1) return K_STUB;
    else                                   return K_POOL;
  endfunction

  // Source input bit for each output bit of the remap register; -1 gives zero.
  function automatic int remap_src(input int unsigned dst);
    case (dst)
      0: return 1;
      1: return 2;
      3: return 0;
      4: return 4;
      5: return 3;
      6: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] remap_bits(input logic [7:0] d);
    logic [7:0] r;
    r = '0;
    for (int unsigned i = 0; i < 8; i++) begin
      if (remap_src(i) >= 0) r[i] = d[remap_src(i)];
    end
    return r;
  endfunction

endpackage

// File: rtl/rb_addr_seq.sv
module rb_addr_seq #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic          acc_first,
  input  logic [AW-1:0] acc_addr,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] ptr_q
);
  assign eff_addr = acc_first ? acc_addr : ptr_q;

  always_ff @(posedge clk) begin
    if (rst)            ptr_q <= '0;
    else if (acc_valid) ptr_q <= eff_addr + AW'(1);
  end
endmodule

// File: rtl/rb_pool.sv
module rb_pool #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/rb_dyn.sv
module rb_dyn
  import regbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  kind_e      kind,
  input  logic [7:0] wdata,
  output logic [3:0] pwr_field,
  output logic       reboot_pulse,
  output logic       wdog_pulse,
  output logic [7:0] remap_q,
  output logic [7:0] lcd_q
);
  logic       pwr_wr;
  logic [7:0] pwr_masked;

  assign pwr_wr     = wr_en && (kind == K_PWR);
  assign pwr_masked = wdata & PWR_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_field    <= '0;
      reboot_pulse <= 1'b0;
      wdog_pulse   <= 1'b0;
      remap_q      <= '0;
      lcd_q        <= '0;
    end else begin
      reboot_pulse <= pwr_wr && wdata[PWR_REBOOT_BIT];
      wdog_pulse   <= pwr_wr && wdata[PWR_WDOG_BIT];
      if (pwr_wr) pwr_field <= pwr_masked[3:0];
      if (wr_en && kind == K_REMAP) remap_q <= remap_bits(wdata);
      if (wr_en && kind == K_LCD)   lcd_q   <= wdata & LCD_MASK;
    end
  end
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 8,
  parameter int unsigned POOL_DEPTH = 128,
  localparam int unsigned IW        = $clog2(POOL_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic          acc_first,
  input  logic          acc_we,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [3:0]    pwr_field,
  output logic          reboot_pulse,
  output logic          wdog_pulse,
  output logic [DW-1:0] remap_q,
  output logic [DW-1:0] lcd_q
);
  logic [AW-1:0] eff_addr;
  logic [AW-1:0] ptr_q;
  kind_e         kind;
  logic          hit_hole;
  logic          hit_wo;
  logic          pool_we;
  logic          rd_req;
  logic [DW-1:0] pool_rdata;
  logic [DW-1:0] rd_mux;

  rb_addr_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_first(acc_first),
    .acc_addr(acc_addr), .eff_addr(eff_addr), .ptr_q(ptr_q)
  );

  assign kind     = classify(eff_addr);
  assign hit_hole = (kind == K_HOLE);
  assign hit_wo   = (kind != K_HOLE) && (kind != K_POOL);
  assign pool_we  = acc_valid && acc_we && (kind == K_POOL);
  assign rd_req   = acc_valid && !acc_we;

  rb_pool #(.DEPTH(POOL_DEPTH), .DW(DW)) u_pool (
    .clk(clk), .rst(rst), .we(pool_we), .idx(eff_addr[IW-1:0]),
    .wdata(acc_wdata), .rdata(pool_rdata)
  );

  rb_dyn u_dyn (
    .clk(clk), .rst(rst), .wr_en(acc_valid && acc_we), .kind(kind),
    .wdata(acc_wdata), .pwr_field(pwr_field), .reboot_pulse(reboot_pulse),
    .wdog_pulse(wdog_pulse), .remap_q(remap_q), .lcd_q(lcd_q)
  );

  always_comb begin
    if (kind == K_POOL)  rd_mux = pool_rdata;
    else if (hit_hole)   rd_mux = '1;
    else                 rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk (
  input logic       clk,
  input logic       rst,
  input logic       acc_valid,
  input logic       acc_first,
  input logic       acc_we,
  input logic [7:0] acc_wdata,
  input logic [7:0] eff_addr,
  input logic [7:0] ptr_q,
  input logic       hit_hole,
  input logic       hit_wo,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic [3:0] pwr_field,
  input logic       reboot_pulse,
  input logic       wdog_pulse,
  input logic [7:0] remap_q,
  input logic [7:0] lcd_q
);
  assert_rd_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_we) |=> rd_valid);
  assert_no_spurious_rd_R2: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && !acc_we) |=> !rd_valid);
  assert_next_addr_R3: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (ptr_q == $past(eff_addr) + 8'd1));
  assert_follow_ptr_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_first) |-> (eff_addr == ptr_q));
  assert_hole_ff_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_we && hit_hole) |=> (rd_data == 8'hFF));
  assert_pwr_only_on_write_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(pwr_field) |-> $past(acc_valid && acc_we && eff_addr == 8'h20));
  assert_reboot_cause_R6: assert property (@(posedge clk) disable iff (rst)
    reboot_pulse |-> $past(acc_valid && acc_we && eff_addr == 8'h20 && acc_wdata[2]));
  assert_wdog_cause_R6: assert property (@(posedge clk) disable iff (rst)
    wdog_pulse |-> $past(acc_valid && acc_we && eff_addr == 8'h20 && acc_wdata[4]));
  assert_remap_zero_bits_R7: assert property (@(posedge clk) disable iff (rst)
    (remap_q[2] == 1'b0) && (remap_q[7] == 1'b0));
  assert_lcd_high_clear_R8: assert property (@(posedge clk) disable iff (rst)
    lcd_q[7:6] == 2'b00);
  assert_wo_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_we && hit_wo) |=> (rd_data == 8'h00));
endmodule

bind regbank_top regbank_chk u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_first(acc_first),
  .acc_we(acc_we), .acc_wdata(acc_wdata), .eff_addr(eff_addr), .ptr_q(ptr_q),
  .hit_hole(hit_hole), .hit_wo(hit_wo), .rd_valid(rd_valid), .rd_data(rd_data),
  .pwr_field(pwr_field), .reboot_pulse(reboot_pulse), .wdog_pulse(wdog_pulse),
  .remap_q(remap_q), .lcd_q(lcd_q)
);

// File: tb/tb_regbank_top.sv
module tb_regbank_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       acc_valid, acc_first, acc_we;
  logic [7:0] acc_addr, acc_wdata;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [3:0] pwr_field;
  logic       reboot_pulse, wdog_pulse;
  logic [7:0] remap_q, lcd_q;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  regbank_top dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_first(acc_first),
    .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .pwr_field(pwr_field),
    .reboot_pulse(reboot_pulse), .wdog_pulse(wdog_pulse),
    .remap_q(remap_q), .lcd_q(lcd_q)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // One beat, then idle; returns at the negedge where its results are visible.
  task automatic beat(input logic first, input logic we, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_first = first; acc_we = we; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_first = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd_check(input logic first, input logic [7:0] a, input logic [7:0] exp, input string tag);
    beat(first, 1'b0, a, 8'h00);
    check({7'd0, rd_valid}, 8'd1, {tag, " rd_valid"});
    check(rd_data, exp, tag);
  endtask

  function automatic logic [7:0] exp_remap(input logic [7:0] d);
    return {1'b0, d[5], d[3], d[4], d[0], 1'b0, d[2], d[1]};
  endfunction

  function automatic bit is_absent(input logic [7:0] a);
    return (a >= 8'h80) || (a inside {[8'h58:8'h5F]}) || (a inside {[8'h62:8'h7E]});
  endfunction

  task automatic t_reset();
    check({4'd0, pwr_field}, 8'h00, "R1 pwr_field");
    check(remap_q, 8'h00, "R1 remap_q");
    check(lcd_q, 8'h00, "R1 lcd_q");
    check({6'd0, reboot_pulse, wdog_pulse}, 8'h00, "R1 pulses");
    check({7'd0, rd_valid}, 8'h00, "R1 rd_valid");
    rd_check(1'b1, 8'h10, 8'h00, "R1 storage 0x10");
    rd_check(1'b1, 8'h7F, 8'h00, "R1 storage 0x7F");
  endtask

  task automatic t_pool();
    beat(1'b1, 1'b1, 8'h05, 8'hA5);
    beat(1'b1, 1'b1, 8'h4F, 8'h3C);
    beat(1'b1, 1'b1, 8'h7F, 8'h81);
    beat(1'b1, 1'b1, 8'h00, 8'h99);
    rd_check(1'b1, 8'h05, 8'hA5, "R2 0x05");
    rd_check(1'b1, 8'h4F, 8'h3C, "R2 0x4F");
    rd_check(1'b1, 8'h7F, 8'h81, "R2 0x7F");
    rd_check(1'b1, 8'h00, 8'h99, "R2 0x00");
  endtask

  task automatic t_burst();
    for (int i = 0; i < 4; i++) beat(i == 0, 1'b1, 8'h30, 8'h10 + 8'(i));
    for (int i = 0; i < 4; i++) rd_check(i == 0, 8'h30, 8'h10 + 8'(i), "R3 burst read");
    rd_check(1'b1, 8'hFF, 8'hFF, "R3 start at 0xFF");
    rd_check(1'b0, 8'h00, 8'h99, "R3 wrap to 0x00");
  endtask

  task automatic t_holes();
    beat(1'b1, 1'b1, 8'h80, 8'h11);
    beat(1'b1, 1'b1, 8'hCF, 8'h12);
    beat(1'b1, 1'b1, 8'h5A, 8'h22);
    beat(1'b1, 1'b1, 8'h62, 8'h33);
    beat(1'b1, 1'b1, 8'h7E, 8'h44);
    rd_check(1'b1, 8'h80, 8'hFF, "R4 0x80");
    rd_check(1'b1, 8'h5A, 8'hFF, "R4 0x5A");
    rd_check(1'b1, 8'h62, 8'hFF, "R4 0x62");
    rd_check(1'b1, 8'h7E, 8'hFF, "R4 0x7E");
    rd_check(1'b1, 8'h00, 8'h99, "R4 0x00 untouched by 0x80");
    rd_check(1'b1, 8'h4F, 8'h3C, "R4 0x4F untouched by 0xCF");
    check({4'd0, pwr_field}, 8'h00, "R4 outputs untouched");
  endtask

  task automatic t_cross();
    for (int i = 0; i < 12; i++) beat(i == 0, 1'b1, 8'h56, 8'hC0 + 8'(i));
    for (int i = 0; i < 12; i++) begin
      logic [7:0] a;
      a = 8'h56 + 8'(i);
      rd_check(i == 0, 8'h56, is_absent(a) ? 8'hFF : 8'hC0 + 8'(i), "R11 burst through hole");
    end
  endtask

  task automatic t_pwr();
    beat(1'b1, 1'b1, 8'h20, 8'hF4);
    check({6'd0, reboot_pulse, wdog_pulse}, 8'h03, "R6 both pulses together");
    check({4'd0, pwr_field}, 8'h04, "R5 masked field");
    @(negedge clk);
    check({6'd0, reboot_pulse, wdog_pulse}, 8'h00, "R6 pulses one cycle");
    check({4'd0, pwr_field}, 8'h04, "R5 field held");
    beat(1'b1, 1'b1, 8'h20, 8'h03);
    check({6'd0, reboot_pulse, wdog_pulse}, 8'h00, "R6 no pulse without bits");
    check({4'd0, pwr_field}, 8'h03, "R5 field 3");
    beat(1'b1, 1'b1, 8'h20, 8'h10);
    check({6'd0, reboot_pulse, wdog_pulse}, 8'h01, "R6 watchdog alone");
    check({4'd0, pwr_field}, 8'h00, "R5 bit4 not stored");
  endtask

  task automatic t_remap();
    logic [7:0] vals [4] = '{8'h01, 8'h7F, 8'h40, 8'h02};
    foreach (vals[i]) begin
      beat(1'b1, 1'b1, 8'h21, vals[i]);
      check(remap_q, exp_remap(vals[i]), "R7 permutation");
    end
    check(exp_remap(8'h7F), 8'h7B, "R7 table sanity");
  endtask

  task automatic t_lcd();
    beat(1'b1, 1'b1, 8'h22, 8'hFF);
    check(lcd_q, 8'h3F, "R8 mask");
    beat(1'b1, 1'b1, 8'h22, 8'hA0);
    check(lcd_q, 8'h20, "R8 backlight bit");
  endtask

  task automatic t_stub();
    logic [7:0] r0, l0;
    logic [3:0] p0;
    r0 = remap_q; l0 = lcd_q; p0 = pwr_field;
    beat(1'b1, 1'b1, 8'h24, 8'h5D);
    beat(1'b1, 1'b1, 8'h23, 8'hFF);
    check({6'd0, reboot_pulse, wdog_pulse}, 8'h00, "R9 stub 0x23 pulses");
    beat(1'b1, 1'b1, 8'h2F, 8'hFF);
    check(remap_q, r0, "R9 remap unchanged");
    check(lcd_q, l0, "R9 lcd unchanged");
    check({4'd0, pwr_field}, {4'd0, p0}, "R9 pwr unchanged");
    rd_check(1'b1, 8'h24, 8'h5D, "R9 neighbour 0x24");
    rd_check(1'b1, 8'h2E, 8'h00, "R9 neighbour 0x2E");
    rd_check(1'b1, 8'h23, 8'h00, "R9 stub 0x23 read");
    rd_check(1'b1, 8'h2F, 8'h00, "R9 stub 0x2F read");
  endtask

  task automatic t_wo();
    rd_check(1'b1, 8'h20, 8'h00, "R10 read 0x20");
    rd_check(1'b0, 8'h21, 8'h00, "R10 read 0x21");
    rd_check(1'b0, 8'h22, 8'h00, "R10 read 0x22");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    rst = 1'b1; acc_valid = 1'b0; acc_first = 1'b0; acc_we = 1'b0;
    acc_addr = 8'h00; acc_wdata = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pool();
    t_burst();
    t_holes();
    t_cross();
    t_pwr();
    t_remap();
    t_lcd();
    t_stub();
    t_wo();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end
endmodule